// File: doc/BRIEF.md
# I2C Arbitration-Loss Detector

This block watches an I2C port that is transmitting and reports when another device has won the bus. It compares the bit the port is sending with the SDA level that is actually on the wire, and it samples on every rising edge of SCL. Both lines arrive already synchronised to the system clock. A mismatch counts only when the port wants a released, high line and reads low. The acknowledge slot does not count while the port is receiving, because there the port drives its own acknowledge.

Two update policies are available. In the per-bit policy the loss flag follows each check: it is set by a mismatch and cleared by the next clean check. In the per-byte policy any mismatch is remembered for the whole frame, and the flag is raised on the falling SCL edge of the 9th clock. Hardware never clears it after that; software clears it between bytes. As an option, the block removes permission to drive SDA on the same clock that the flag is raised. Permission stays removed until software clears the flag or a new START begins.

Top module: `i2c_arb_loss`

## Requirements
- R1: After reset, `lost_o` is 0 and `sda_oe_o` is 1.
- R2: In per-bit policy (`byte_mode_i`=0), a clock in which SCL is first seen high while `tx_bit_i`=1 and `sda_i`=0 makes `lost_o` 1 from the next clock.
- R3: In per-bit policy, a rising-edge check without a mismatch makes `lost_o` 0 from the next clock. Sending 0 while reading 1 is not a mismatch.
- R4: In per-byte policy (`byte_mode_i`=1), the rising-edge checks are accumulated. `lost_o` stays unchanged until the clock in which SCL is first seen low with `bit_idx_i`=8 (the 9th clock; positions run 0..8). On that clock it becomes 1 from the next clock if any mismatch was collected. The accumulator is emptied on that clock and on `start_i`.
- R5: In per-byte policy, once `lost_o` is 1 it stays 1 until `clr_i`, even across frames without a mismatch.
- R6: When `is_rx_i`=1, a check at `bit_idx_i`=8 never counts as a mismatch. With `is_rx_i`=0 the same slot is checked normally.
- R7: `clr_i` makes `lost_o` 0 and `sda_oe_o` 1 from the next clock. This holds even when a set happens on the same clock.
- R8: With `release_en_i`=1, `sda_oe_o` falls on the same clock that `lost_o` is raised. With `release_en_i`=0, `sda_oe_o` stays 1.
- R9: Once `sda_oe_o` is 0 it stays 0 until `clr_i` or `start_i`, even if the per-bit flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| tx_bit_i | input | 1 | Bit the port is sending in the current slot |
| bit_idx_i | input | IDX_W | Slot position in the frame, 0..8 (8 = acknowledge) |
| is_rx_i | input | 1 | Port is receiving; the acknowledge slot is not checked |
| byte_mode_i | input | 1 | 0 = per-bit policy, 1 = per-byte policy |
| release_en_i | input | 1 | Release SDA when the flag is raised |
| start_i | input | 1 | New START: empties accumulator, lifts release |
| clr_i | input | 1 | Software clear of flag and release |
| lost_o | output | 1 | Arbitration-lost flag |
| sda_oe_o | output | 1 | 1 = port may drive SDA, 0 = forced high impedance |

## Verification
The comparison is tried with matched frames, with a single "sent 1, read 0" bit, and with the opposite "sent 0, read 1" case. These tell a real loss apart from a harmless difference. The same mismatch is placed in the acknowledge slot with and without receive mode, which shows that the exclusion depends on the slot and the direction. In per-byte policy, the flag is read just before and just after the 9th falling edge, and a clean frame after a loss shows that the flag holds. A START inside a byte with a mismatch shows that the accumulator is emptied. A clear on the same clock as a set shows which one has priority, and a release followed by a clean per-bit check shows that the gate outlives the flag.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
    typedef struct packed {
        logic acc;   // mismatch seen in current frame
        logic flag;  // arbitration-lost flag
        logic rel;   // SDA drive withdrawn
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{acc: 1'b0, flag: 1'b0, rel: 1'b0};
endpackage

// File: rtl/i2c_arb_edge.sv
module i2c_arb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;  // idle bus is high
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/i2c_arb_cmp.sv
module i2c_arb_cmp #(
    parameter int IDX_W   = 4,
    parameter int ACK_IDX = 8
) (
    input  logic             tx_bit_i,
    input  logic             sda_i,
    input  logic             is_rx_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    output logic             mis_o
);
    logic ack_slot;

    always_comb begin
        ack_slot = (bit_idx_i == IDX_W'(ACK_IDX));
        // only a released-high line pulled low by someone else is a loss
        mis_o    = tx_bit_i & ~sda_i & ~(is_rx_i & ack_slot);
    end
endmodule

// File: rtl/i2c_arb_loss.sv
module i2c_arb_loss #(
    parameter int FRAME_BITS = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scl_i,
    input  logic                           sda_i,
    input  logic                           tx_bit_i,
    input  logic [$clog2(FRAME_BITS)-1:0]  bit_idx_i,
    input  logic                           is_rx_i,
    input  logic                           byte_mode_i,
    input  logic                           release_en_i,
    input  logic                           start_i,
    input  logic                           clr_i,
    output logic                           lost_o,
    output logic                           sda_oe_o
);
    import i2c_arb_pkg::*;

    localparam int IDX_W   = $clog2(FRAME_BITS);
    localparam int ACK_IDX = FRAME_BITS - 1;

    logic scl_rise, scl_fall, mis;
    logic set_ev;
    arb_state_t st_d, st_q;

    i2c_arb_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (scl_i),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    i2c_arb_cmp #(.IDX_W(IDX_W), .ACK_IDX(ACK_IDX)) u_cmp (
        .tx_bit_i  (tx_bit_i),
        .sda_i     (sda_i),
        .is_rx_i   (is_rx_i),
        .bit_idx_i (bit_idx_i),
        .mis_o     (mis)
    );

    always_comb begin
        st_d   = st_q;
        set_ev = 1'b0;
        if (!byte_mode_i) begin
            if (scl_rise) begin
                st_d.flag = mis;
                set_ev    = mis;
            end
        end else begin
            if (scl_rise && mis) st_d.acc = 1'b1;
            if (scl_fall && bit_idx_i == IDX_W'(ACK_IDX)) begin
                if (st_q.acc) begin
                    st_d.flag = 1'b1;
                    set_ev    = 1'b1;
                end
                st_d.acc = 1'b0;
            end
        end
        if (set_ev && release_en_i) st_d.rel = 1'b1;
        if (start_i) begin
            st_d.acc = 1'b0;
            st_d.rel = 1'b0;
        end
        if (clr_i) begin
            st_d.flag = 1'b0;
            st_d.rel  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARB_RESET;
        else        st_q <= st_d;
    end

    assign lost_o   = st_q.flag;
    assign sda_oe_o = ~st_q.rel;
endmodule

// File: rtl/i2c_arb_loss_chk.sv
module i2c_arb_loss_chk #(
    parameter int IDX_W   = 4,
    parameter int ACK_IDX = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_i,
    input logic             tx_bit_i,
    input logic [IDX_W-1:0] bit_idx_i,
    input logic             is_rx_i,
    input logic             byte_mode_i,
    input logic             release_en_i,
    input logic             start_i,
    input logic             clr_i,
    input logic             lost_o,
    input logic             sda_oe_o
);
    p_bit_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode_i && $rose(scl_i) && tx_bit_i && !sda_i && !clr_i &&
         !(is_rx_i && bit_idx_i == IDX_W'(ACK_IDX))) |=> lost_o);

    p_bit_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode_i && $rose(scl_i) && !(tx_bit_i && !sda_i)) |=> !lost_o);

    p_byte_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode_i && !lost_o &&
         !($fell(scl_i) && bit_idx_i == IDX_W'(ACK_IDX))) |=> !lost_o);

    p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode_i && lost_o && !clr_i) |=> lost_o);

    p_rx_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode_i && $rose(scl_i) && is_rx_i &&
         bit_idx_i == IDX_W'(ACK_IDX)) |=> !lost_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!lost_o && sda_oe_o));

    p_no_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o && !release_en_i) |=> sda_oe_o);

    p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sda_oe_o && !clr_i && !start_i) |=> !sda_oe_o);
endmodule

bind i2c_arb_loss i2c_arb_loss_chk #(.IDX_W(IDX_W), .ACK_IDX(ACK_IDX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .tx_bit_i     (tx_bit_i),
    .bit_idx_i    (bit_idx_i),
    .is_rx_i      (is_rx_i),
    .byte_mode_i  (byte_mode_i),
    .release_en_i (release_en_i),
    .start_i      (start_i),
    .clr_i        (clr_i),
    .lost_o       (lost_o),
    .sda_oe_o     (sda_oe_o)
);

// File: tb/i2c_arb_loss_test.sv
`timescale 1ns/1ps
module i2c_arb_loss_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, txb = 1'b1;
    logic [3:0] idx = '0;
    logic       is_rx = 1'b0, bmode = 1'b0, rel_en = 1'b0, start = 1'b0, clr = 1'b0;
    logic       lost, oe;

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    i2c_arb_loss uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .tx_bit_i(txb),
        .bit_idx_i(idx), .is_rx_i(is_rx), .byte_mode_i(bmode),
        .release_en_i(rel_en), .start_i(start), .clr_i(clr),
        .lost_o(lost), .sda_oe_o(oe)
    );

    // behavioural reference, evaluated at each rising clock edge
    bit m_scl_old = 1, m_seen = 0, m_flag = 0, m_held = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_scl_old = 1; m_seen = 0; m_flag = 0; m_held = 0;
        end else begin
            bit bad, raised;
            bad = (txb == 1 && sda == 0 && !(is_rx == 1 && idx == 8));
            raised = 0;
            if (bmode == 0 && scl == 1 && m_scl_old == 0) begin
                m_flag = bad; raised = bad;
            end
            if (bmode == 1 && scl == 1 && m_scl_old == 0 && bad) m_seen = 1;
            if (bmode == 1 && scl == 0 && m_scl_old == 1 && idx == 8) begin
                if (m_seen) begin m_flag = 1; raised = 1; end
                m_seen = 0;
            end
            if (raised && rel_en) m_held = 1;
            if (start) begin m_seen = 0; m_held = 0; end
            if (clr) begin m_flag = 0; m_held = 0; end
            m_scl_old = scl;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (lost !== m_flag || oe !== !m_held) begin
                errors++;
                $display("FAIL %s model: lost=%0b oe=%0b expected lost=%0b oe=%0b",
                         phase, lost, oe, m_flag, !m_held);
            end
        end
    end

    task automatic expect_out(input string tag, input logic el, input logic eo);
        checks++;
        if (lost !== el || oe !== eo) begin
            errors++;
            $display("FAIL %s: lost=%0b oe=%0b expected lost=%0b oe=%0b", tag, lost, oe, el, eo);
        end
    endtask

    // drop SCL (old slot index kept), set up the slot, raise SCL, wait one clock
    task automatic bit_slot(input logic t, input logic s, input int p);
        @(negedge clk) scl = 0;
        @(negedge clk) begin idx = 4'(p); txb = t; sda = s; end
        @(negedge clk) scl = 1;
        @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] t, input logic [7:0] s, input logic at, input logic as_);
        for (int i = 0; i < 8; i++) bit_slot(t[7-i], s[7-i], i);
        bit_slot(at, as_, 8);
    endtask

    task automatic drop_scl();
        @(negedge clk) scl = 0;
        @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1;
        @(negedge clk) sig = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: expired expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_out("R1", 0, 1);

        // per-bit policy, no release
        phase = "R2";
        frame(8'hA5, 8'hA5, 1, 1);
        expect_out("R3", 0, 1);
        bit_slot(1, 0, 2);
        expect_out("R2", 1, 1);
        expect_out("R8", 1, 1);
        phase = "R3";
        bit_slot(1, 1, 3);
        expect_out("R3", 0, 1);
        bit_slot(0, 1, 4);
        expect_out("R3", 0, 1);

        // acknowledge slot while receiving
        phase = "R6";
        is_rx = 1;
        bit_slot(1, 0, 8);
        expect_out("R6", 0, 1);
        is_rx = 0;
        bit_slot(1, 0, 8);
        expect_out("R6", 1, 1);
        pulse(clr);
        expect_out("R7", 0, 1);

        // per-byte policy with release
        phase = "R4";
        bmode = 1; rel_en = 1;
        pulse(start);
        frame(8'hF0, 8'hE0, 1, 1);   // mismatch at slot 3
        expect_out("R4", 0, 1);      // scl high at slot 8, not yet latched
        drop_scl();
        expect_out("R4", 1, 0);
        expect_out("R8", 1, 0);
        phase = "R5";
        frame(8'h3C, 8'h3C, 0, 0);
        drop_scl();
        expect_out("R5", 1, 0);
        expect_out("R9", 1, 0);
        phase = "R7";
        pulse(clr);
        expect_out("R7", 0, 1);

        // START empties the accumulator
        phase = "R4";
        frame(8'h80, 8'h00, 1, 1);   // mismatch at slot 0
        @(negedge clk) scl = 0;      // 9th fall latches it
        @(negedge clk);
        expect_out("R4", 1, 0);
        pulse(clr);
        for (int i = 0; i < 4; i++) bit_slot(i == 1, 0, i);  // mismatch at slot 1
        pulse(start);
        for (int i = 4; i < 8; i++) bit_slot(1, 1, i);
        bit_slot(1, 1, 8);
        drop_scl();
        expect_out("R4", 0, 1);

        // clear wins over a simultaneous set
        phase = "R7";
        bmode = 0;
        @(negedge clk) scl = 0;
        @(negedge clk) begin idx = 5; txb = 1; sda = 0; end
        @(negedge clk) begin scl = 1; clr = 1; end
        @(negedge clk) clr = 0;
        expect_out("R7", 0, 1);

        // release outlives the per-bit flag, START lifts it
        phase = "R9";
        bit_slot(1, 0, 6);
        expect_out("R8", 1, 0);
        bit_slot(1, 1, 7);
        expect_out("R9", 0, 0);
        pulse(start);
        expect_out("R9", 0, 1);

        // release disabled
        phase = "R8";
        rel_en = 0;
        bit_slot(1, 0, 1);
        expect_out("R8", 1, 1);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule